// File: doc/BRIEF.md
# Channel-Status Block Relay

This block carries the channel-status bits of a two-channel digital audio stream (channels A and B) from a receive side to a transmit side. The two sides run at different block rates. The block uses three whole-block stages. A capture stage collects one status bit per channel on each receive frame strobe. On the strobe for the last frame of a block, the whole capture image moves into a middle stage. The middle stage is mapped into a byte-wide host window, so software can inspect the block or change it. When the transmitter asks for frame 0 of a new outgoing block, the whole middle image moves into a send stage. The send stage then supplies the bits for every frame of that outgoing block.

Blocks only ever move as complete images. If the transmit side runs faster, it repeats the last block it took. If the receive side runs faster, the blocks that complete between two outgoing block starts overwrite one another, and only the newest is sent. A hold input stops receive blocks from replacing a block that the host is editing. Both sides run on one clock and are paced by single-cycle frame strobes that carry a frame index.

Top module: `cs_block_relay`

## Requirements
- R1: After reset all three stages hold zero, tx_cs_a and tx_cs_b are 0, and every host read returns 0.
- R2: A cycle with rx_stb high stores rx_cs_a and rx_cs_b at frame rx_idx (0..191) of the capture stage. When rx_idx is 191 and hold_load is low, the whole capture image, including that last bit, replaces the middle stage in the same cycle.
- R3: While hold_load is high, a frame-191 receive strobe leaves the middle stage unchanged. The capture stage still records bits.
- R4: Host byte k (0..23) of channel A is at address 32+k, and of channel B at 56+k. Bit 7 of the byte holds frame 8k and bit 0 holds frame 8k+7, so bit 7 at address 32 is frame 0 of channel A. A read returns the middle stage's current value combinationally.
- R5: Reads of addresses below 32 or above 79 return 0, and writes there change nothing.
- R6: A host write to 32..79 replaces that middle-stage byte. If it falls in the same cycle as a capture-to-middle copy, the written byte overrides the copied byte.
- R7: A transmit request for frame 0 copies the whole middle stage into the send stage. The frame-0 bits come from that copied image. Frames 1..191 come from the send stage and do not follow later middle-stage changes.
- R8: tx_cs_a and tx_cs_b change only in the cycle after a transmit request. For a request with tx_idx above 191 they become 0.
- R9: With no new completed receive block, successive outgoing blocks repeat the same content. When several receive blocks complete between two frame-0 requests, only the newest is sent.
- R10: A host write in the same cycle as a frame-0 transmit request is deferred by one cycle. The send stage gets the pre-write contents, a read in the next cycle still shows the old byte, and from the cycle after that the new byte is visible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_stb | input | 1 | Receive frame strobe |
| rx_idx | input | 8 | Frame index of the received bits |
| rx_cs_a | input | 1 | Received status bit, channel A |
| rx_cs_b | input | 1 | Received status bit, channel B |
| hold_load | input | 1 | Blocks capture-to-middle copies while high |
| host_addr | input | 7 | Host byte address |
| host_we | input | 1 | Host write enable |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data (combinational) |
| tx_req | input | 1 | Transmit frame request |
| tx_idx | input | 8 | Requested outgoing frame index |
| tx_cs_a | output | 1 | Outgoing status bit, channel A |
| tx_cs_b | output | 1 | Outgoing status bit, channel B |

## Verification
Two pairs of functions can land on the middle stage in the same cycle. One pair is a host write and the frame-0 copy into the send stage. The other is a host write and the frame-191 copy from the capture stage. The bench drives each pair in one cycle, on purpose. It then reads the touched byte back in the next cycles and plays out the outgoing block, which shows whether the send stage took the pre-write byte and when the write became visible. A long run with interleaved strobes at unequal rates, plus occasional host writes, lets the two copies and the writes fall together in many phase relations.

// File: rtl/csr_pkg.sv
package csr_pkg;
   localparam int unsigned CSR_BLK_BITS = 192;
   localparam int unsigned CSR_BYTE_W   = 8;
   localparam int unsigned CSR_ADDR_W   = 7;
   localparam int unsigned CSR_BASE     = 32;
endpackage

// File: rtl/csr_rx_stage.sv
module csr_rx_stage #(
   parameter int unsigned BLK = 192,
   parameter int unsigned NCH = 2,
   parameter int unsigned FW  = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stb,
   input  logic [FW-1:0]     idx,
   input  logic [NCH-1:0]    bits,
   output logic [NCH*BLK-1:0] img_next,
   output logic              blk_end
);
   localparam int unsigned IW  = NCH*BLK;
   localparam int unsigned IXW = $clog2(IW);
   localparam logic [FW-1:0] LAST_F = FW'(BLK-1);

   logic [IW-1:0] d_q;
   logic          in_rng;

   assign in_rng  = (32'(idx) < BLK);
   assign blk_end = stb && (idx == LAST_F);

   // capture image with the current strobe's bits merged in
   always_comb begin
      img_next = d_q;
      if (stb && in_rng) begin
         for (int c = 0; c < NCH; c++) begin
            img_next[IXW'(c*BLK + 32'(idx))] = bits[c];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)   d_q <= '0;
      else if (stb) d_q <= img_next;
   end
endmodule

// File: rtl/csr_mid_stage.sv
module csr_mid_stage #(
   parameter int unsigned BLK  = 192,
   parameter int unsigned NCH  = 2,
   parameter int unsigned BW   = 8,
   parameter int unsigned AW   = 7,
   parameter int unsigned BASE = 32
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [NCH*BLK-1:0] load_img,
   input  logic               busy,
   input  logic               wr,
   input  logic [AW-1:0]      addr,
   input  logic [BW-1:0]      wdata,
   output logic [NCH*BLK-1:0] img,
   output logic [BW-1:0]      rdata,
   output logic               pend_v
);
   localparam int unsigned IW     = NCH*BLK;
   localparam int unsigned IXW    = $clog2(IW);
   localparam int unsigned BYTES  = BLK/BW;
   localparam int unsigned NBYTES = NCH*BYTES;
   localparam int unsigned IDXW   = $clog2(NBYTES);

   logic [IW-1:0]   e_q, e_n;
   logic [BW-1:0]   view [NBYTES];
   logic [31:0]     a_u;
   logic            hit;
   logic [IDXW-1:0] idx;
   logic [IDXW-1:0] pend_idx;
   logic [BW-1:0]   pend_data;

   function automatic logic [BW-1:0] rev(input logic [BW-1:0] v);
      logic [BW-1:0] r;
      for (int j = 0; j < BW; j++) r[j] = v[BW-1-j];
      return r;
   endfunction

   function automatic logic [IXW-1:0] byte_pos(input logic [IDXW-1:0] i);
      return IXW'((32'(i) / BYTES) * BLK + (32'(i) % BYTES) * BW);
   endfunction

   // address decode
   always_comb begin
      a_u = 32'(addr);
      hit = (a_u >= BASE) && (a_u < BASE + NBYTES);
      idx = hit ? IDXW'(a_u - BASE) : '0;
   end

   // byte view of the stored image, earliest frame in the MSB
   for (genvar g = 0; g < NBYTES; g++) begin : g_view
      localparam int unsigned POS = (g / BYTES) * BLK + (g % BYTES) * BW;
      assign view[g] = rev(e_q[POS +: BW]);
   end

   assign rdata = hit ? view[idx] : '0;

   // update order: whole-block load, deferred write, fresh write
   always_comb begin
      e_n = e_q;
      if (load)               e_n = load_img;
      if (pend_v)             e_n[byte_pos(pend_idx) +: BW] = rev(pend_data);
      if (wr && hit && !busy) e_n[byte_pos(idx) +: BW]      = rev(wdata);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         e_q       <= '0;
         pend_v    <= 1'b0;
         pend_idx  <= '0;
         pend_data <= '0;
      end else begin
         e_q    <= e_n;
         pend_v <= wr && hit && busy;
         if (wr && hit && busy) begin
            pend_idx  <= idx;
            pend_data <= wdata;
         end
      end
   end

   assign img = e_q;
endmodule

// File: rtl/csr_tx_stage.sv
module csr_tx_stage #(
   parameter int unsigned BLK = 192,
   parameter int unsigned NCH = 2,
   parameter int unsigned FW  = 8
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req,
   input  logic [FW-1:0]      idx,
   input  logic [NCH*BLK-1:0] src_img,
   output logic [NCH*BLK-1:0] f_img,
   output logic [NCH-1:0]     bits,
   output logic               copy
);
   localparam int unsigned IW  = NCH*BLK;
   localparam int unsigned IXW = $clog2(IW);

   logic [IW-1:0]  f_q;
   logic [NCH-1:0] pick;
   logic           in_rng;

   assign copy   = req && (idx == '0);
   assign in_rng = (32'(idx) < BLK);

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic [IXW-1:0] pos;
      assign pos     = IXW'(c*BLK + 32'(idx));
      assign pick[c] = !in_rng ? 1'b0 : (copy ? src_img[pos] : f_q[pos]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         f_q  <= '0;
         bits <= '0;
      end else begin
         if (copy) f_q  <= src_img;
         if (req)  bits <= pick;
      end
   end

   assign f_img = f_q;
endmodule

// File: rtl/cs_block_relay.sv
module cs_block_relay
   import csr_pkg::*;
#(
   parameter int unsigned BLK  = CSR_BLK_BITS,
   parameter int unsigned BW   = CSR_BYTE_W,
   parameter int unsigned AW   = CSR_ADDR_W,
   parameter int unsigned BASE = CSR_BASE,
   parameter int unsigned FW   = $clog2(BLK)
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rx_stb,
   input  logic [FW-1:0] rx_idx,
   input  logic          rx_cs_a,
   input  logic          rx_cs_b,
   input  logic          hold_load,
   input  logic [AW-1:0] host_addr,
   input  logic          host_we,
   input  logic [BW-1:0] host_wdata,
   output logic [BW-1:0] host_rdata,
   input  logic          tx_req,
   input  logic [FW-1:0] tx_idx,
   output logic          tx_cs_a,
   output logic          tx_cs_b
);
   localparam int unsigned NCH = 2;
   localparam int unsigned IW  = NCH*BLK;

   if (BLK % BW != 0) begin : g_bad_pack
      $error("block length must be a whole number of bytes");
   end
   if (BASE + NCH*(BLK/BW) > (1 << AW)) begin : g_bad_map
      $error("host window does not fit the address width");
   end
   if ((1 << FW) < BLK) begin : g_bad_idx
      $error("frame index too narrow for the block length");
   end

   logic [IW-1:0]  d_next, e_img, f_img;
   logic           blk_end, e_load, f_copy, pend_v;
   logic [NCH-1:0] tx_bits;

   assign e_load = blk_end && !hold_load;

   csr_rx_stage #(.BLK(BLK), .NCH(NCH), .FW(FW)) rx_i (
      .clk(clk), .rst_n(rst_n), .stb(rx_stb), .idx(rx_idx),
      .bits({rx_cs_b, rx_cs_a}), .img_next(d_next), .blk_end(blk_end)
   );

   csr_mid_stage #(.BLK(BLK), .NCH(NCH), .BW(BW), .AW(AW), .BASE(BASE)) mid_i (
      .clk(clk), .rst_n(rst_n), .load(e_load), .load_img(d_next),
      .busy(f_copy), .wr(host_we), .addr(host_addr), .wdata(host_wdata),
      .img(e_img), .rdata(host_rdata), .pend_v(pend_v)
   );

   csr_tx_stage #(.BLK(BLK), .NCH(NCH), .FW(FW)) tx_i (
      .clk(clk), .rst_n(rst_n), .req(tx_req), .idx(tx_idx),
      .src_img(e_img), .f_img(f_img), .bits(tx_bits), .copy(f_copy)
   );

   assign tx_cs_a = tx_bits[0];
   assign tx_cs_b = tx_bits[1];
endmodule

// File: rtl/csr_relay_chk.sv
module csr_relay_chk #(
   parameter int unsigned BLK  = 192,
   parameter int unsigned BW   = 8,
   parameter int unsigned AW   = 7,
   parameter int unsigned BASE = 32,
   parameter int unsigned FW   = 8,
   parameter int unsigned IW   = 384
)(
   input logic          clk,
   input logic          rst_n,
   input logic          rx_stb,
   input logic [FW-1:0] rx_idx,
   input logic          hold_load,
   input logic [AW-1:0] host_addr,
   input logic          host_we,
   input logic [BW-1:0] host_rdata,
   input logic          tx_req,
   input logic [FW-1:0] tx_idx,
   input logic          tx_cs_a,
   input logic          tx_cs_b,
   input logic [IW-1:0] e_img,
   input logic [IW-1:0] f_img,
   input logic          pend_v
);
   localparam logic [FW-1:0] LAST_F = FW'(BLK-1);
   localparam int unsigned   TOP_A  = BASE + 2*(BLK/BW);

   logic in_win;
   assign in_win = (32'(host_addr) >= BASE) && (32'(host_addr) < TOP_A);

   // R8
   tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_req |=> ($stable(tx_cs_a) && $stable(tx_cs_b)));

   // R8
   tx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_req && (tx_idx > LAST_F)) |=> (!tx_cs_a && !tx_cs_b));

   // R5
   rd_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_win |-> (host_rdata == '0));

   // R7
   f_whole_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_req && (tx_idx == '0)) |=> $stable(f_img));

   // R3
   hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_load && rx_stb && (rx_idx == LAST_F) && !host_we && !pend_v) |=> $stable(e_img));

   // R10
   defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_req && (tx_idx == '0) && host_we && in_win) |=> pend_v);
endmodule

bind cs_block_relay csr_relay_chk #(
   .BLK(BLK), .BW(BW), .AW(AW), .BASE(BASE), .FW(FW), .IW(IW)
) chk_i (
   .clk(clk), .rst_n(rst_n), .rx_stb(rx_stb), .rx_idx(rx_idx),
   .hold_load(hold_load), .host_addr(host_addr), .host_we(host_we),
   .host_rdata(host_rdata), .tx_req(tx_req), .tx_idx(tx_idx),
   .tx_cs_a(tx_cs_a), .tx_cs_b(tx_cs_b), .e_img(e_img), .f_img(f_img),
   .pend_v(pend_v)
);

// File: tb/cs_block_relay_tb_top.sv
module cs_block_relay_tb_top;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int BLK = 192;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       rx_stb, rx_cs_a, rx_cs_b, hold_load, host_we, tx_req;
   logic [7:0] rx_idx, tx_idx, host_wdata, host_rdata;
   logic [6:0] host_addr;
   logic       tx_cs_a, tx_cs_b;

   always #5 clk = ~clk;

   cs_block_relay dut_i (
      .clk(clk), .rst_n(rst_n), .rx_stb(rx_stb), .rx_idx(rx_idx),
      .rx_cs_a(rx_cs_a), .rx_cs_b(rx_cs_b), .hold_load(hold_load),
      .host_addr(host_addr), .host_we(host_we), .host_wdata(host_wdata),
      .host_rdata(host_rdata), .tx_req(tx_req), .tx_idx(tx_idx),
      .tx_cs_a(tx_cs_a), .tx_cs_b(tx_cs_b)
   );

   // reference images, index = frame
   logic [BLK-1:0] md [2];
   logic [BLK-1:0] me [2];
   logic [BLK-1:0] mf [2];
   logic           mp_v;
   int             mp_a;
   logic [7:0]     mp_d;
   logic           hold_v;

   typedef struct packed {
      logic [1:0] bits;
      logic [7:0] fr;
   } exp_t;
   exp_t exp_q[$];

   int   n_chk = 0;
   int   n_bad = 0;
   logic req_seen = 1'b0;

   task automatic chk(input string rq, input int act, input int expv);
      n_chk++;
      if (act != expv) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, expv);
      end
   endtask

   function automatic logic pat(input int id, input int ch, input int f);
      return ((f*(id+2) + ch*5 + id*3) % 7) < 3;
   endfunction

   function automatic logic [7:0] model_rd(input int ad);
      logic [7:0] v;
      int ch, k;
      v = '0;
      if (ad >= 32 && ad < 80) begin
         ch = (ad - 32) / 24;
         k  = (ad - 32) % 24;
         for (int j = 0; j < 8; j++) v[7-j] = me[ch][8*k+j];
      end
      return v;
   endfunction

   task automatic model_wr(input int ad, input logic [7:0] d);
      int ch, k;
      ch = (ad - 32) / 24;
      k  = (ad - 32) % 24;
      for (int j = 0; j < 8; j++) me[ch][8*k+j] = d[7-j];
   endtask

   // scoreboard monitor: one expected item per request, compared a cycle later
   always @(posedge clk) req_seen <= rst_n && tx_req;

   always @(negedge clk) begin
      if (req_seen) begin
         if (exp_q.size() == 0) begin
            n_chk++; n_bad++;
            $display("FAIL R8 actual=output expected=no output");
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            chk($sformatf("R7/R8/R9 frame %0d", e.fr), {30'd0, tx_cs_b, tx_cs_a}, {30'd0, e.bits});
         end
      end
   end

   // one clock of stimulus plus the reference update
   task automatic step(input logic rs, input int rf, input logic ra, input logic rb,
                       input logic tr, input int tf,
                       input logic we, input int ad, input logic [7:0] wd,
                       input logic rdchk, input string rq);
      logic busy, hit;
      exp_t e;
      @(negedge clk);
      rx_stb = rs; rx_idx = 8'(rf); rx_cs_a = ra; rx_cs_b = rb;
      tx_req = tr; tx_idx = 8'(tf);
      host_we = we; host_addr = 7'(ad); host_wdata = wd;
      hold_load = hold_v;
      #1;
      if (rdchk) chk(rq, int'(host_rdata), int'(model_rd(ad)));
      busy = tr && (tf == 0);
      if (tr) begin
         e.fr = 8'(tf);
         if (tf >= BLK)      e.bits = 2'b00;
         else if (tf == 0)   e.bits = {me[1][0], me[0][0]};
         else                e.bits = {mf[1][tf], mf[0][tf]};
         exp_q.push_back(e);
         if (busy) begin mf[0] = me[0]; mf[1] = me[1]; end
      end
      if (rs && rf < BLK) begin md[0][rf] = ra; md[1][rf] = rb; end
      if (rs && rf == BLK-1 && !hold_v) begin me[0] = md[0]; me[1] = md[1]; end
      if (mp_v) begin model_wr(mp_a, mp_d); mp_v = 1'b0; end
      hit = (ad >= 32 && ad < 80);
      if (we && hit) begin
         if (busy) begin mp_v = 1'b1; mp_a = ad; mp_d = wd; end
         else model_wr(ad, wd);
      end
   endtask

   task automatic idle();
      step(0, 0, 0, 0, 0, 0, 0, 0, 8'h00, 0, "");
   endtask

   task automatic rd(input int ad, input string rq);
      step(0, 0, 0, 0, 0, 0, 0, ad, 8'h00, 1, rq);
   endtask

   task automatic wr(input int ad, input logic [7:0] d);
      step(0, 0, 0, 0, 0, 0, 1, ad, d, 0, "");
   endtask

   task automatic rx_block(input int id);
      for (int f = 0; f < BLK; f++) step(1, f, pat(id, 0, f), pat(id, 1, f), 0, 0, 0, 0, 8'h00, 0, "");
   endtask

   task automatic tx_block();
      for (int f = 0; f < BLK; f++) step(0, 0, 0, 0, 1, f, 0, 0, 8'h00, 0, "");
   endtask

   task automatic read_all(input string rq);
      for (int a = 32; a < 80; a++) rd(a, rq);
   endtask

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin
      for (int c = 0; c < 2; c++) begin md[c] = '0; me[c] = '0; mf[c] = '0; end
      mp_v = 1'b0; mp_a = 0; mp_d = '0; hold_v = 1'b0;
      rst_n = 1'b0;
      rx_stb = 0; rx_idx = 0; rx_cs_a = 0; rx_cs_b = 0; hold_load = 0;
      host_we = 0; host_addr = 0; host_wdata = 0; tx_req = 0; tx_idx = 0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      chk("R1 tx outputs", {30'd0, tx_cs_b, tx_cs_a}, 0);
      rd(32, "R1 read after reset");
      rd(79, "R1 read after reset");
      step(0, 0, 0, 0, 1, 7, 0, 0, 8'h00, 0, "");   // R1 send stage empty

      // R2 R4 capture a block, middle stage loads on frame 191
      rx_block(1);
      read_all("R2/R4 loaded block");
      // R5 reads outside the window
      rd(31, "R5 below window");
      rd(80, "R5 above window");
      rd(0, "R5 address 0");
      rd(127, "R5 address 127");

      // R7 outgoing block takes the middle image; R9 repeats it
      tx_block();
      tx_block();

      // R9 skip: two blocks received, only the newest is sent
      rx_block(2);
      rx_block(3);
      tx_block();

      // R3 hold keeps the middle stage
      hold_v = 1'b1;
      rx_block(4);
      read_all("R3 held block");
      hold_v = 1'b0;

      // R6 host edit is read back and sent; R5 writes outside are ignored
      wr(40, 8'hA5);
      wr(20, 8'hFF);
      wr(100, 8'h5A);
      rd(40, "R6 written byte");
      read_all("R5 after stray writes");
      tx_block();

      // R10 write together with frame-0 request
      step(0, 0, 0, 0, 1, 0, 1, 33, 8'h3C, 0, "");
      rd(33, "R10 old byte next cycle");
      rd(33, "R10 new byte after deferral");
      for (int f = 1; f < BLK; f++) step(0, 0, 0, 0, 1, f, 0, 0, 8'h00, 0, "");

      // R6 host write together with capture-to-middle copy
      for (int f = 0; f < BLK-1; f++) step(1, f, pat(5, 0, f), pat(5, 1, f), 0, 0, 0, 0, 8'h00, 0, "");
      step(1, BLK-1, 1'b1, 1'b0, 0, 0, 1, 60, 8'h81, 0, "");
      rd(60, "R6 write wins over load");
      rd(59, "R6 neighbour from load");
      rd(32, "R2 loaded byte");

      // R8 out-of-range request
      step(0, 0, 0, 0, 1, 200, 0, 0, 8'h00, 0, "");
      step(0, 0, 0, 0, 1, 255, 0, 0, 8'h00, 0, "");

      // R9 R10 interleaved unequal rates with sparse host writes
      begin
         int rf, tf, blk_id;
         rf = 0; tf = 0; blk_id = 10;
         for (int i = 0; i < 4000; i++) begin
            logic rs, tr, we;
            rs = (i % 3 == 0);
            tr = (i % 2 == 0);
            we = (i % 97 == 0);
            step(rs, rf, pat(blk_id, 0, rf), pat(blk_id, 1, rf), tr, tf,
                 we, 32 + (i % 48), 8'(i * 7), (i % 13 == 5), "R9 interleaved read");
            if (rs) begin
               if (rf == BLK-1) begin rf = 0; blk_id++; end else rf++;
            end
            if (tr) tf = (tf == BLK-1) ? 0 : tf + 1;
         end
      end

      idle();
      idle();
      chk("R8 scoreboard drained", exp_q.size(), 0);
      summary();
      $finish;
   end
endmodule